// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit data-processing datapath. In a single combinational pass it takes an operand, a shift-type code, a shift amount and the current carry flag. It returns the shifted operand and the carry that the shift produces. Five shift types are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry. Each type follows its own carry rule at the amount boundaries: zero, a full word (32), and more than a full word.

The block contains no state. The amount is first classified as zero, in range or over range, and is then clamped. A log-depth right-shift chain, one bit wider than the operand, produces the shifted value and the carry bit together. Left shifts are built by mirroring the operand around that same chain. A separate log-depth rotate chain serves rotations. A final selector chooses the result and the carry by shift type.

Top module: `barrel_shifter`

## Requirements
- R1: Only amount bits 7..0 are used. An amount whose bits 31..8 differ but whose bits 7..0 are equal gives the same result and carry-out.
- R2: For type codes 0 to 3, an amount of 0 returns the operand unchanged and carry-out equals carry-in.
- R3: Type code 0 is logical left shift. For n from 1 to 32 the result is operand << n (0 when n = 32) and the carry-out is operand bit (32 - n).
- R4: For type codes 0 and 1 with n greater than 32, both the result and the carry-out are 0.
- R5: Type code 1 is logical right shift. For n from 1 to 32 the result is operand >> n with zero fill (0 when n = 32) and the carry-out is operand bit (n - 1).
- R6: Type code 2 is arithmetic right shift. For n from 1 to 32 the vacated upper bits take operand bit 31 and the carry-out is operand bit (n - 1).
- R7: For type code 2 with n of 32 or more, every result bit and the carry-out equal operand bit 31.
- R8: Type code 3 is rotate right. For nonzero n the operand is rotated right by n mod 32 and the carry-out equals result bit 31. This also applies when n mod 32 is 0, for example n = 32 or n = 64.
- R9: Type code 4 is rotate right through carry. The amount is ignored. The result is {carry-in, operand bits 31..1} and the carry-out is operand bit 0.
- R10: Type codes 5, 6 and 7 return the operand unchanged and carry-out equals carry-in, for any amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted |
| kind_i | input | 3 | Shift-type code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry) |
| amount_i | input | 32 | Shift amount; only bits 7..0 are used |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
Two functions can meet in one evaluation: the saturation of the result and the carry pick, each taken from a different end of the operand. The sharpest cases are an amount of exactly 32, where a left or logical right shift empties the word but the carry still takes bit 0 or bit 31, and a rotate by a nonzero multiple of 32, where the value is unchanged but the carry stops following carry-in and becomes bit 31. These cases are provoked both directly and through random amounts that are biased toward 0, 31, 32, 33 and values with high bits set. Each output is judged against a bench model written with plain 64-bit arithmetic.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/bshift_amount_class.sv
module bshift_amount_class #(
    parameter int DATA_W    = 32,
    parameter int AMT_USE_W = 8,
    parameter int CLAMP_W   = $clog2(DATA_W + 1),
    parameter int ROT_W     = $clog2(DATA_W)
) (
    input  logic [AMT_USE_W-1:0] amt_i,
    output logic                 zero_o,
    output logic                 over_o,
    output logic [CLAMP_W-1:0]   clamp_o,
    output logic [ROT_W-1:0]     rot_o
);

    localparam logic [AMT_USE_W-1:0] FULL_AMT = AMT_USE_W'(DATA_W);

    always_comb begin
        zero_o  = (amt_i == '0);
        over_o  = (amt_i > FULL_AMT);
        clamp_o = over_o ? CLAMP_W'(DATA_W) : amt_i[CLAMP_W-1:0];
        rot_o   = amt_i[ROT_W-1:0];
    end

endmodule

// File: rtl/bshift_fill_chain.sv
module bshift_fill_chain #(
    parameter int W   = 33,
    parameter int STG = 6
) (
    input  logic [W-1:0]   data_i,
    input  logic           fill_i,
    input  logic [STG-1:0] amt_i,
    output logic [W-1:0]   data_o
);

    logic [W-1:0] lvl [STG+1];

    assign lvl[0] = data_i;

    for (genvar i = 0; i < STG; i++) begin : g_stage
        localparam int S = 1 << i;
        if (S >= W) begin : g_flood
            assign lvl[i+1] = amt_i[i] ? {W{fill_i}} : lvl[i];
        end else begin : g_shift
            assign lvl[i+1] = amt_i[i] ? {{S{fill_i}}, lvl[i][W-1:S]} : lvl[i];
        end
    end

    assign data_o = lvl[STG];

endmodule

// File: rtl/bshift_rot_chain.sv
module bshift_rot_chain #(
    parameter int W   = 32,
    parameter int STG = 5
) (
    input  logic [W-1:0]   data_i,
    input  logic [STG-1:0] amt_i,
    output logic [W-1:0]   data_o
);

    logic [W-1:0] lvl [STG+1];

    assign lvl[0] = data_i;

    for (genvar i = 0; i < STG; i++) begin : g_stage
        localparam int S = (1 << i) % W;
        if (S == 0) begin : g_ident
            assign lvl[i+1] = lvl[i];
        end else begin : g_rot
            assign lvl[i+1] = amt_i[i] ? {lvl[i][S-1:0], lvl[i][W-1:S]} : lvl[i];
        end
    end

    assign data_o = lvl[STG];

endmodule

// File: rtl/bshift_select.sv
module bshift_select
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        kind_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    input  logic              zero_i,
    input  logic              over_i,
    input  logic [DATA_W:0]   fill_out_i,
    input  logic [DATA_W-1:0] rot_out_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] mirrored;
    shift_kind_e       kind;

    always_comb begin
        shifted = fill_out_i[DATA_W:1];
        for (int b = 0; b < DATA_W; b++) begin
            mirrored[b] = shifted[DATA_W-1-b];
        end
    end

    always_comb begin
        kind     = shift_kind_e'(kind_i);
        result_o = operand_i;
        carry_o  = carry_i;
        case (kind)
            SK_LSL: begin
                if (!zero_i) begin
                    result_o = over_i ? '0 : mirrored;
                    carry_o  = over_i ? 1'b0 : fill_out_i[0];
                end
            end
            SK_LSR: begin
                if (!zero_i) begin
                    result_o = over_i ? '0 : shifted;
                    carry_o  = over_i ? 1'b0 : fill_out_i[0];
                end
            end
            SK_ASR: begin
                if (!zero_i) begin
                    result_o = shifted;
                    carry_o  = fill_out_i[0];
                end
            end
            SK_ROR: begin
                if (!zero_i) begin
                    result_o = rot_out_i;
                    carry_o  = rot_out_i[DATA_W-1];
                end
            end
            SK_RRX: begin
                result_o = {carry_i, operand_i[DATA_W-1:1]};
                carry_o  = operand_i[0];
            end
            default: begin
                result_o = operand_i;
                carry_o  = carry_i;
            end
        endcase
    end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
    import bshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int AMT_IN_W  = 32,
    parameter int AMT_USE_W = 8
) (
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [2:0]          kind_i,
    input  logic [AMT_IN_W-1:0] amount_i,
    input  logic                carry_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                carry_o
);

    localparam int EXT_W   = DATA_W + 1;
    localparam int CLAMP_W = $clog2(DATA_W + 1);
    localparam int ROT_W   = $clog2(DATA_W);

    logic [AMT_USE_W-1:0] amt_low;
    logic                 amt_zero;
    logic                 amt_over;
    logic [CLAMP_W-1:0]   amt_clamp;
    logic [ROT_W-1:0]     amt_rot;
    logic [DATA_W-1:0]    operand_rev;
    logic [EXT_W-1:0]     chain_in;
    logic                 chain_fill;
    logic [EXT_W-1:0]     chain_out;
    logic [DATA_W-1:0]    rot_out;

    assign amt_low = amount_i[AMT_USE_W-1:0];

    if (AMT_IN_W > AMT_USE_W) begin : g_hi_amt
        logic unused_amt_hi;
        assign unused_amt_hi = ^amount_i[AMT_IN_W-1:AMT_USE_W];
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign operand_rev[b] = operand_i[DATA_W-1-b];
    end

    always_comb begin
        chain_in   = (kind_i == SK_LSL) ? {operand_rev, 1'b0} : {operand_i, 1'b0};
        chain_fill = (kind_i == SK_ASR) ? operand_i[DATA_W-1] : 1'b0;
    end

    bshift_amount_class #(
        .DATA_W   (DATA_W),
        .AMT_USE_W(AMT_USE_W),
        .CLAMP_W  (CLAMP_W),
        .ROT_W    (ROT_W)
    ) u_class (
        .amt_i  (amt_low),
        .zero_o (amt_zero),
        .over_o (amt_over),
        .clamp_o(amt_clamp),
        .rot_o  (amt_rot)
    );

    bshift_fill_chain #(
        .W  (EXT_W),
        .STG(CLAMP_W)
    ) u_fill (
        .data_i(chain_in),
        .fill_i(chain_fill),
        .amt_i (amt_clamp),
        .data_o(chain_out)
    );

    bshift_rot_chain #(
        .W  (DATA_W),
        .STG(ROT_W)
    ) u_rot (
        .data_i(operand_i),
        .amt_i (amt_rot),
        .data_o(rot_out)
    );

    bshift_select #(
        .DATA_W(DATA_W)
    ) u_sel (
        .kind_i    (kind_i),
        .operand_i (operand_i),
        .carry_i   (carry_i),
        .zero_i    (amt_zero),
        .over_i    (amt_over),
        .fill_out_i(chain_out),
        .rot_out_i (rot_out),
        .result_o  (result_o),
        .carry_o   (carry_o)
    );

    // Output checks against the port-level rules
    always_comb begin
        if (kind_i <= 3'd3 && amt_low == '0) begin
            assert_zero_pass_R2: assert (result_o == operand_i && carry_o == carry_i)
                else $error("zero amount must pass operand and carry");
        end
        if (kind_i >= 3'd5) begin
            assert_spare_code_R10: assert (result_o == operand_i && carry_o == carry_i)
                else $error("spare code must pass operand and carry");
        end
        if ((kind_i == 3'd0 || kind_i == 3'd1) && amt_low > AMT_USE_W'(DATA_W)) begin
            assert_logic_over_R4: assert (result_o == '0 && !carry_o)
                else $error("over-range logical shift must clear result and carry");
        end
        if (kind_i == 3'd2 && amt_low >= AMT_USE_W'(DATA_W)) begin
            assert_asr_sat_R7: assert (result_o == {DATA_W{operand_i[DATA_W-1]}}
                                       && carry_o == operand_i[DATA_W-1])
                else $error("saturated arithmetic shift must copy sign");
        end
        if (kind_i == 3'd3 && amt_low != '0) begin
            assert_ror_carry_R8: assert (carry_o == result_o[DATA_W-1])
                else $error("rotate carry must equal top result bit");
        end
        if (kind_i == 3'd4) begin
            assert_rrx_bits_R9: assert (carry_o == operand_i[0] && result_o[DATA_W-1] == carry_i)
                else $error("rotate through carry bit placement");
        end
    end

endmodule

// File: tb/tb_barrel_shifter.sv
module tb_barrel_shifter;

    logic        clk;
    logic [31:0] operand;
    logic [2:0]  kind;
    logic [31:0] amount;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    barrel_shifter dut (
        .operand_i(operand),
        .kind_i   (kind),
        .amount_i (amount),
        .carry_i  (cin),
        .result_o (result),
        .carry_o  (cout)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic logic [32:0] model(input logic [31:0] op, input logic [2:0] k,
                                          input logic [31:0] amt, input logic ci);
        int unsigned n;
        logic [63:0] wide;
        logic [31:0] r;
        logic        c;
        n = amt & 32'hff;
        r = op;
        c = ci;
        case (k)
            3'd0: if (n != 0) begin
                if (n > 32) begin r = 0; c = 0; end
                else begin wide = {32'b0, op} << n; r = wide[31:0]; c = wide[32]; end
            end
            3'd1: if (n != 0) begin
                if (n > 32) begin r = 0; c = 0; end
                else begin wide = {op, 32'b0} >> n; r = wide[63:32]; c = wide[31]; end
            end
            3'd2: if (n != 0) begin
                int unsigned m;
                m = (n > 32) ? 32 : n;
                wide = 64'($signed({op, 32'b0}) >>> m);
                r = wide[63:32];
                c = wide[31];
            end
            3'd3: if (n != 0) begin
                int unsigned m;
                m = n % 32;
                wide = {op, op} >> m;
                r = wide[31:0];
                c = r[31];
            end
            3'd4: begin r = {ci, op[31:1]}; c = op[0]; end
            default: ;
        endcase
        return {c, r};
    endfunction

    function automatic string tag_of(input logic [2:0] k, input logic [31:0] amt);
        int unsigned n;
        string t;
        n = amt & 32'hff;
        case (k)
            3'd0: t = (n == 0) ? "R2" : (n > 32) ? "R4" : "R3";
            3'd1: t = (n == 0) ? "R2" : (n > 32) ? "R4" : "R5";
            3'd2: t = (n == 0) ? "R2" : (n >= 32) ? "R7" : "R6";
            3'd3: t = (n == 0) ? "R2" : "R8";
            3'd4: t = "R9";
            default: t = "R10";
        endcase
        if (amt[31:8] != 0) t = {"R1+", t};
        return t;
    endfunction

    task automatic apply(input logic [31:0] op, input logic [2:0] k,
                         input logic [31:0] amt, input logic ci);
        logic [32:0] exp;
        @(negedge clk);
        operand = op; kind = k; amount = amt; cin = ci;
        @(posedge clk);
        #1;
        exp = model(op, k, amt, ci);
        checks++;
        if (result !== exp[31:0] || cout !== exp[32]) begin
            failures++;
            $display("FAIL %s kind=%0d amt=%h op=%h cin=%0d: got res=%h c=%0d expected res=%h c=%0d",
                     tag_of(k, amt), k, amt, op, ci, result, cout, exp[31:0], exp[32]);
        end
    endtask

    // R1: compare two amounts sharing bits 7..0
    task automatic check_hi_ignored(input logic [31:0] op, input logic [2:0] k,
                                    input logic [7:0] lo, input logic ci);
        logic [31:0] r_a;
        logic        c_a;
        apply(op, k, {24'h0, lo}, ci);
        r_a = result; c_a = cout;
        apply(op, k, {24'hA5_3C_71, lo}, ci);
        checks++;
        if (result !== r_a || cout !== c_a) begin
            failures++;
            $display("FAIL R1 high amount bits changed output: got res=%h c=%0d expected res=%h c=%0d",
                     result, cout, r_a, c_a);
        end
    endtask

    initial begin
        logic [31:0] pats [4];
        int unsigned corner [8];
        void'($urandom(32'd20240611));
        operand = '0; kind = '0; amount = '0; cin = 1'b0;
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hDEAD_BEEF;
        pats[3] = 32'h0000_0000;
        corner[0] = 0; corner[1] = 1; corner[2] = 31; corner[3] = 32;
        corner[4] = 33; corner[5] = 64; corner[6] = 255; corner[7] = 16;

        // Idle inputs: zero operand, code 0, amount 0 (R2)
        #1;
        checks++;
        if (result !== 32'h0 || cout !== 1'b0) begin
            failures++;
            $display("FAIL R2 idle state: got res=%h c=%0d expected res=0 c=0", result, cout);
        end

        // Directed corners over every code, amount and carry-in (R2..R10)
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 8; a++) begin
                    apply(pats[p], 3'(k), corner[a], 1'b0);
                    apply(pats[p], 3'(k), corner[a], 1'b1);
                end
            end
        end

        // R1: upper amount bits
        check_hi_ignored(32'hDEAD_BEEF, 3'd0, 8'd4, 1'b0);
        check_hi_ignored(32'h8000_0000, 3'd2, 8'd0, 1'b1);
        check_hi_ignored(32'h1234_5678, 3'd3, 8'd40, 1'b0);
        check_hi_ignored(32'hF000_000F, 3'd1, 8'd32, 1'b1);

        // Constrained random stimulus
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] op;
            logic [31:0] amt;
            logic [2:0]  k;
            int unsigned sel;
            op  = $urandom();
            k   = 3'($urandom_range(0, 7));
            sel = $urandom_range(0, 9);
            case (sel)
                0: amt = 32'd0;
                1: amt = 32'd32;
                2: amt = 32'd31 + 32'($urandom_range(0, 2));
                3: amt = $urandom();
                4: amt = {24'($urandom()), 8'd32};
                default: amt = 32'($urandom_range(1, 40));
            endcase
            apply(op, k, amt, 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired: got running expected done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule